// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block steps the current address and counters of one active DMA channel, one element at a time. A one-cycle `load` pulse captures a start address, an X (row) count, a Y (row number) count, signed 16-bit X and Y strides, and three mode bits. From then on, every `elem_done` pulse moves the address by the X stride and counts the row down. When a row ends, the block does one of two things. In 2D mode with rows left, it steps to the next row. Otherwise the work unit ends, and the channel either stops with a done status or asks for its next descriptor.

The engine is a state machine with four states. `ST_IDLE` means not running. `ST_RUN` means stepping. `ST_WAIT_DESC` means the work unit is finished and a descriptor reload has been requested, while the channel still counts as running. `ST_HALT` means stopped by a transfer error. The transitions are:
- *load*: any state to `ST_RUN`.
- *finish-stop*: `ST_RUN` to `ST_IDLE`.
- *finish-chain*: `ST_RUN` to `ST_WAIT_DESC`.
- *fault*: `ST_RUN` or `ST_WAIT_DESC` to `ST_HALT`.

Row wraps and plain steps keep the machine in `ST_RUN`. The parent fetches the descriptor, then issues a new `load`.

Top module: `dma2d_agen`

## Requirements
- R1: One cycle after `load`, the outputs are `cur_addr` = `start_addr`, `cur_x` = `x_count` (or 65535 if `x_count` is 0), `cur_y` = `y_count` (or 65535 if 0), `run` = 1, `done` = 0 and `err` = 0. The mode and stride inputs are captured at the same time. `load` wins over every other input in that cycle, and it works from any state.
- R2: In `ST_RUN`, an `elem_done` pulse with `cur_x` not equal to 1 adds the sign-extended X stride to `cur_addr` modulo 2^32 and decrements `cur_x`.
- R3: When an element ends a row (`cur_x` is 1), `row_irq` pulses for exactly one cycle if the captured `row_irq_en` is 1. If `row_irq_en` is 0, `row_irq` stays 0.
- R4: At a row end with `mode_2d` = 1 and `cur_y` > 1, the block wraps to the next row. `cur_y` decrements, `cur_x` reloads the effective X count, and `cur_addr` becomes `cur_addr` + sext(X stride) − sext(X stride) + sext(Y stride), which is `cur_addr` + sext(Y stride).
- R5: At the final row end (`mode_2d` = 0, or `cur_y` ≤ 1) with `flow_stop` = 1, `cur_addr` takes the X step, `cur_x` becomes 0, `run` clears and `done` sets.
- R6: At the final row end with `flow_stop` = 0, `cur_addr` takes the X step and `cur_x` becomes 0. `desc_req` pulses for one cycle, `run` stays 1, and later `elem_done` pulses change nothing until the next `load`.
- R7: `xfer_err` while `run` is 1 sets `err`, clears `run` and stops stepping. No `desc_req` follows, and later `elem_done` pulses change nothing. `xfer_err` wins over `elem_done` in the same cycle. `xfer_err` while `run` is 0 is ignored.
- R8: While `run` is 0, `elem_done` leaves `cur_addr`, `cur_x` and `cur_y` unchanged.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start pulse that captures the work-unit parameters |
| start_addr | input | 32 | First element address |
| x_count | input | 16 | Elements per row (0 means 65536 − 1 = 65535) |
| x_stride | input | 16 | Signed per-element address step |
| y_count | input | 16 | Rows per unit (0 means 65535) |
| y_stride | input | 16 | Signed row-to-row address step |
| mode_2d | input | 1 | 1 = wrap rows, 0 = single row |
| flow_stop | input | 1 | 1 = stop when done, 0 = request next descriptor |
| row_irq_en | input | 1 | Enable the per-row interrupt pulse |
| elem_done | input | 1 | One element has been transferred |
| xfer_err | input | 1 | Transfer error |
| cur_addr | output | 32 | Current address |
| cur_x | output | 16 | Elements left in this row |
| cur_y | output | 16 | Rows left |
| run | output | 1 | Channel is active |
| done | output | 1 | Unit finished in stop mode |
| err | output | 1 | Stopped by an error |
| row_irq | output | 1 | One-cycle row-end interrupt |
| desc_req | output | 1 | One-cycle descriptor reload request |

## Verification
Any fault in the datapath reaches the ports quickly. A wrong stride sign, a missed wrap rewind or a bad count reload shows up on `cur_addr`, `cur_x` or `cur_y` one clock after the `elem_done` that caused it, because all three are state registers.

Errors in the state register show up differently. A bad next-state choice shows up as a wrong `run`/`done`/`err` combination. It can also show up as an address that keeps moving in `ST_WAIT_DESC` or `ST_HALT` on the next element pulse. A pulse that is lost or doubled on `row_irq` or `desc_req` is visible in the very cycle after the row end.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RUN       = 2'd1,
        ST_WAIT_DESC = 2'd2,
        ST_HALT      = 2'd3
    } dma2d_state_e;
endpackage

// File: rtl/dma2d_cfg.sv
// Captures per-unit parameters on load; zero counts become all-ones.
module dma2d_cfg #(
    parameter int CNT_W = 16,
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] x_count,
    input  logic [MOD_W-1:0] x_stride,
    input  logic [MOD_W-1:0] y_stride,
    input  logic             mode_2d,
    input  logic             flow_stop,
    input  logic             row_irq_en,
    output logic [CNT_W-1:0] q_xcnt,
    output logic [MOD_W-1:0] q_xstr,
    output logic [MOD_W-1:0] q_ystr,
    output logic             q_2d,
    output logic             q_stop,
    output logic             q_irq_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_xcnt   <= '0;
            q_xstr   <= '0;
            q_ystr   <= '0;
            q_2d     <= 1'b0;
            q_stop   <= 1'b0;
            q_irq_en <= 1'b0;
        end else if (load) begin
            q_xcnt   <= (x_count == '0) ? '1 : x_count;
            q_xstr   <= x_stride;
            q_ystr   <= y_stride;
            q_2d     <= mode_2d;
            q_stop   <= flow_stop;
            q_irq_en <= row_irq_en;
        end
    end
endmodule

// File: rtl/dma2d_step.sv
// Combinational next-address and row-end decode.
module dma2d_step #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int MOD_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  xc,
    input  logic [CNT_W-1:0]  yc,
    input  logic [MOD_W-1:0]  xstr,
    input  logic [MOD_W-1:0]  ystr,
    input  logic              is_2d,
    output logic [ADDR_W-1:0] addr_elem,
    output logic [ADDR_W-1:0] addr_row,
    output logic              row_end,
    output logic              wrap
);
    localparam int EXT_W = ADDR_W - MOD_W;
    logic [ADDR_W-1:0] xs_ext, ys_ext;

    assign xs_ext    = {{EXT_W{xstr[MOD_W-1]}}, xstr};
    assign ys_ext    = {{EXT_W{ystr[MOD_W-1]}}, ystr};
    assign addr_elem = addr + xs_ext;
    // The last X step plus its rewind cancel, so only the Y step remains.
    assign addr_row  = addr + ys_ext;
    assign row_end   = (xc == CNT_W'(1));
    assign wrap      = is_2d && (yc > CNT_W'(1));
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int MOD_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  x_count,
    input  logic [MOD_W-1:0]  x_stride,
    input  logic [CNT_W-1:0]  y_count,
    input  logic [MOD_W-1:0]  y_stride,
    input  logic              mode_2d,
    input  logic              flow_stop,
    input  logic              row_irq_en,
    input  logic              elem_done,
    input  logic              xfer_err,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_x,
    output logic [CNT_W-1:0]  cur_y,
    output logic              run,
    output logic              done,
    output logic              err,
    output logic              row_irq,
    output logic              desc_req
);
    import dma2d_pkg::*;

    dma2d_state_e      state, state_nx;
    logic [CNT_W-1:0]  q_xcnt;
    logic [MOD_W-1:0]  q_xstr, q_ystr;
    logic              q_2d, q_stop, q_irq_en;
    logic [ADDR_W-1:0] addr_elem, addr_row;
    logic              row_end, wrap, fire, fault;

    dma2d_cfg #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .x_count(x_count), .x_stride(x_stride), .y_stride(y_stride),
        .mode_2d(mode_2d), .flow_stop(flow_stop), .row_irq_en(row_irq_en),
        .q_xcnt(q_xcnt), .q_xstr(q_xstr), .q_ystr(q_ystr),
        .q_2d(q_2d), .q_stop(q_stop), .q_irq_en(q_irq_en)
    );

    dma2d_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_step (
        .addr(cur_addr), .xc(cur_x), .yc(cur_y),
        .xstr(q_xstr), .ystr(q_ystr), .is_2d(q_2d),
        .addr_elem(addr_elem), .addr_row(addr_row),
        .row_end(row_end), .wrap(wrap)
    );

    assign run   = (state == ST_RUN) || (state == ST_WAIT_DESC);
    assign fault = !load && xfer_err && run;
    assign fire  = !load && !xfer_err && elem_done && (state == ST_RUN);

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (load) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_RUN: begin
                    if (xfer_err)
                        state_nx = ST_HALT;
                    else if (elem_done && row_end && !wrap)
                        state_nx = q_stop ? ST_IDLE : ST_WAIT_DESC;
                end
                ST_WAIT_DESC: if (xfer_err) state_nx = ST_HALT;
                ST_HALT:      state_nx = ST_HALT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_x    <= '0;
            cur_y    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            row_irq  <= 1'b0;
            desc_req <= 1'b0;
        end else begin
            row_irq  <= fire && row_end && q_irq_en;
            desc_req <= fire && row_end && !wrap && !q_stop;
            if (load) begin
                cur_addr <= start_addr;
                cur_x    <= (x_count == '0) ? '1 : x_count;
                cur_y    <= (y_count == '0) ? '1 : y_count;
                done     <= 1'b0;
                err      <= 1'b0;
            end else if (fault) begin
                err <= 1'b1;
            end else if (fire) begin
                if (!row_end) begin
                    cur_addr <= addr_elem;
                    cur_x    <= cur_x - CNT_W'(1);
                end else if (wrap) begin
                    cur_addr <= addr_row;
                    cur_x    <= q_xcnt;
                    cur_y    <= cur_y - CNT_W'(1);
                end else begin
                    cur_addr <= addr_elem;
                    cur_x    <= '0;
                    done     <= q_stop;
                end
            end
        end
    end

    // Assertions
    p_stepping_x_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (cur_x != '0));
    p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        row_irq |-> q_irq_en);
    p_done_excludes_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && run));
    p_desc_req_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |-> (state == ST_WAIT_DESC));
    p_err_stops_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !run);
    p_idle_holds_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cur_addr) && $stable(cur_x) && $stable(cur_y));
    p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req |=> !desc_req);
endmodule

// File: tb/sim_dma2d_agen.sv
module sim_dma2d_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 0, mode_2d = 0, flow_stop = 0, row_irq_en = 0;
    logic        elem_done = 0, xfer_err = 0;
    logic [31:0] start_addr = 0;
    logic [15:0] x_count = 0, x_stride = 0, y_count = 0, y_stride = 0;
    logic [31:0] cur_addr;
    logic [15:0] cur_x, cur_y;
    logic        run, done, err, row_irq, desc_req;

    always #5 clk = ~clk;

    dma2d_agen u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .start_addr(start_addr),
        .x_count(x_count), .x_stride(x_stride), .y_count(y_count),
        .y_stride(y_stride), .mode_2d(mode_2d), .flow_stop(flow_stop),
        .row_irq_en(row_irq_en), .elem_done(elem_done), .xfer_err(xfer_err),
        .cur_addr(cur_addr), .cur_x(cur_x), .cur_y(cur_y), .run(run),
        .done(done), .err(err), .row_irq(row_irq), .desc_req(desc_req)
    );

    int checks = 0, errors = 0;

    // Reference model: 0 idle, 1 run, 2 wait desc, 3 halt
    int          m_st = 0;
    logic [31:0] e_addr = 0;
    logic [15:0] e_x = 0, e_y = 0, c_x = 0, c_xs = 0, c_ys = 0;
    logic        e_done = 0, e_err = 0, e_irq = 0, e_desc = 0;
    logic        c_2d = 0, c_stop = 0, c_ie = 0;
    string       tag = "R9";

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic model;
        logic is_run;
        is_run = (m_st == 1) || (m_st == 2);
        e_irq = 0; e_desc = 0;
        if (load) begin
            tag = "R1";
            e_addr = start_addr;
            e_x = (x_count == 0) ? 16'hFFFF : x_count;
            e_y = (y_count == 0) ? 16'hFFFF : y_count;
            c_x = e_x; c_xs = x_stride; c_ys = y_stride;
            c_2d = mode_2d; c_stop = flow_stop; c_ie = row_irq_en;
            e_done = 0; e_err = 0; m_st = 1;
        end else if (xfer_err && is_run) begin
            tag = "R7"; e_err = 1; m_st = 3;
        end else if (elem_done && m_st == 1 && !xfer_err) begin
            if (e_x != 1) begin
                tag = "R2"; e_addr = e_addr + sext(c_xs); e_x = e_x - 1;
            end else begin
                e_irq = c_ie;
                if (c_2d && e_y > 1) begin
                    tag = "R4/R3";
                    e_addr = e_addr - sext(c_xs) + sext(c_xs) + sext(c_ys);
                    e_x = c_x; e_y = e_y - 1;
                end else begin
                    e_addr = e_addr + sext(c_xs); e_x = 0;
                    if (c_stop) begin tag = "R5/R3"; m_st = 0; e_done = 1; end
                    else begin tag = "R6/R3"; m_st = 2; e_desc = 1; end
                end
            end
        end else if (elem_done) begin
            tag = (m_st == 2) ? "R6" : (m_st == 3) ? "R7" : "R8";
        end else if (xfer_err) begin
            tag = "R7";
        end
    endtask

    task automatic chk(input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
        end
    endtask

    task automatic check_all;
        chk("cur_addr", cur_addr, e_addr);
        chk("cur_x", {16'd0, cur_x}, {16'd0, e_x});
        chk("cur_y", {16'd0, cur_y}, {16'd0, e_y});
        chk("run", {31'd0, run}, {31'd0, (m_st == 1 || m_st == 2)});
        chk("done", {31'd0, done}, {31'd0, e_done});
        chk("err", {31'd0, err}, {31'd0, e_err});
        chk("row_irq", {31'd0, row_irq}, {31'd0, e_irq});
        chk("desc_req", {31'd0, desc_req}, {31'd0, e_desc});
    endtask

    // One clock: inputs already set; model then sample after the edge.
    task automatic tick;
        model();
        @(posedge clk);
        #2;
        check_all();
        @(negedge clk);
        load = 0; elem_done = 0; xfer_err = 0;
    endtask

    task automatic start_unit(input logic [31:0] a, input logic [15:0] xc,
                              input logic [15:0] xs, input logic [15:0] yc,
                              input logic [15:0] ys, input logic m2, input logic fs,
                              input logic ie);
        load = 1; start_addr = a; x_count = xc; x_stride = xs; y_count = yc;
        y_stride = ys; mode_2d = m2; flow_stop = fs; row_irq_en = ie;
        tick();
    endtask

    task automatic elems(input int n);
        for (int i = 0; i < n; i++) begin elem_done = 1; tick(); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        @(negedge clk);
        tag = "R9";
        check_all();                      // R9 reset values
        rst_n = 1;
        @(negedge clk);

        // R8: element pulses while idle
        elem_done = 1; tick();
        xfer_err = 1; tick();             // R7 ignored while not running

        // R1: zero counts become 65535
        start_unit(32'h1000, 16'd0, 16'd1, 16'd0, 16'd0, 1'b1, 1'b1, 1'b0);
        elems(3);

        // R4: 2D, negative X stride, wrap across address zero
        start_unit(32'h0000_0008, 16'd3, 16'hFFFC, 16'd3, 16'hFFE0, 1'b1, 1'b1, 1'b1);
        elems(10);                        // R5 stop reached, then R8 pulse

        // R6: chain mode, further pulses ignored, then R7 in wait
        start_unit(32'hFFFF_FFFE, 16'd2, 16'd2, 16'd5, 16'd100, 1'b0, 1'b0, 1'b1);
        elems(4);
        xfer_err = 1; elem_done = 1; tick();
        elems(2);

        // R7 during stepping, error beats element
        start_unit(32'h40, 16'd4, 16'd4, 16'd2, 16'd8, 1'b1, 1'b1, 1'b0);
        elems(2);
        xfer_err = 1; elem_done = 1; tick();
        elems(2);

        // R1: load overrides element in same cycle, restart while running
        start_unit(32'h80, 16'd5, 16'd1, 16'd1, 16'd0, 1'b0, 1'b1, 1'b1);
        elems(1);
        elem_done = 1;
        start_unit(32'h200, 16'd2, 16'd2, 16'd2, 16'd16, 1'b1, 1'b0, 1'b0);
        elems(8);

        // Random episodes
        for (int ep = 0; ep < 400; ep++) begin
            start_unit($urandom, 16'($urandom_range(1, 4)), 16'($urandom),
                       16'($urandom_range(0, 3) == 0 ? 1 : $urandom_range(1, 4)),
                       16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            for (int c = 0; c < 40; c++) begin
                elem_done = ($urandom_range(0, 9) < 7);
                xfer_err  = ($urandom_range(0, 99) == 0);
                tick();
                if (m_st != 1 && c > 3) break;
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule